// File: doc/BRIEF.md
# Dual-Port Address Collision Arbiter

This block settles contention between two ports of a shared memory. Each port presents an enable, a write request and an address. When both ports are enabled on the same address, the block picks a winner and pulls the active-low busy line of the other port low. The losing port's write is suppressed inside the block.

Arrival order is measured in clock cycles. A port arrives in the cycle in which its enable rises, or in which its address changes while it is enabled. The port that arrived earlier wins. A tie goes to the left port. The decision is locked while the match lasts.

A mode input selects between two roles. As master, the block arbitrates and drives both busy outputs. As slave, the busy outputs stay high, and externally supplied busy inputs gate the writes. Busy and the gated writes follow the inputs within the same cycle. Only the arrival history and the locked winner are held in registers.

Top module: `dp_collision_arb`

## Requirements
- R1: When the addresses differ, or either enable is low, both busy outputs are high (master mode).
- R2: On a collision, the port that arrived in a later cycle sees its busy low in that same cycle. The port that arrived earlier keeps its busy high.
- R3: When both ports arrive in the same cycle on the same address, the left port wins and right busy goes low.
- R4: The two busy outputs are never low together.
- R5: In master mode a port's gated write equals enable AND write request, except that it is forced low while that port's busy output is low.
- R6: In slave mode both busy outputs are high, and each port's gated write equals enable AND write request AND its busy input (low inhibits).
- R7: Arbitration starts in either of two ways. One is an enable rising onto an address that already matches the other port. The other is an address change, with both ports enabled, that creates a match.
- R8: The winner is held for as long as the match lasts, even if later arrivals would reverse the order. Busy is released in the same cycle the match ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_i | input | 1 | 1 = master (arbitrate), 0 = slave |
| l_en_i | input | 1 | Left port enable |
| l_we_i | input | 1 | Left port write request |
| l_addr_i | input | AW | Left port address |
| r_en_i | input | 1 | Right port enable |
| r_we_i | input | 1 | Right port write request |
| r_addr_i | input | AW | Right port address |
| l_busy_ni | input | 1 | Left busy from outside (slave), active low |
| r_busy_ni | input | 1 | Right busy from outside (slave), active low |
| l_busy_no | output | 1 | Left busy, active low |
| r_busy_no | output | 1 | Right busy, active low |
| l_wr_o | output | 1 | Gated left write to the array |
| r_wr_o | output | 1 | Gated right write to the array |

## Verification
Each direction of arrival is driven separately:
- The left port is settled first and the right port enables onto the same address.
- The left port is settled first and the right port moves its address onto the left one.
- The right port is settled first and the left port moves onto it.

Together these show whether the loser is chosen by history rather than by fixed priority, and whether both trigger paths work. A simultaneous enable of both ports onto one address isolates the tie-break. A case where both ports jump together to a new shared address while right holds the win shows whether the lock survives a reversed arrival order. Slave-mode sequences toggle the busy inputs with writes pending, which separates external inhibition from internal arbitration.

// File: rtl/dp_collision_arb_pkg.sv
package dp_collision_arb_pkg;
  typedef enum logic [1:0] {
    WIN_NONE  = 2'd0,
    WIN_LEFT  = 2'd1,
    WIN_RIGHT = 2'd2
  } win_e;
endpackage

// File: rtl/dpa_arrival.sv
// Flags the cycle a port arrives: enable rise or address change while enabled.
module dpa_arrival #(
  parameter int AW = 18
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [AW-1:0] addr_i,
  output logic          fresh_o
);
  logic          en_q;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      en_q   <= en_i;
      addr_q <= addr_i;
    end
  end

  assign fresh_o = en_i && (!en_q || (addr_i != addr_q));
endmodule

// File: rtl/dpa_lock.sv
module dpa_lock
  import dp_collision_arb_pkg::*;
#(
  parameter int AW = 18
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          l_en_i,
  input  logic          r_en_i,
  input  logic [AW-1:0] l_addr_i,
  input  logic [AW-1:0] r_addr_i,
  input  logic          l_fresh_i,
  input  logic          r_fresh_i,
  output logic          l_lose_o,
  output logic          r_lose_o
);
  win_e win_q, win_d;
  logic match;

  assign match = l_en_i && r_en_i && (l_addr_i == r_addr_i);

  always_comb begin
    if (!match)                    win_d = WIN_NONE;
    else if (win_q != WIN_NONE)    win_d = win_q;      // locked for the match
    else if (l_fresh_i && !r_fresh_i) win_d = WIN_RIGHT;
    else                           win_d = WIN_LEFT;   // left earlier, or tie
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) win_q <= WIN_NONE;
    else         win_q <= win_d;
  end

  assign l_lose_o = (win_d == WIN_RIGHT);
  assign r_lose_o = (win_d == WIN_LEFT);
endmodule

// File: rtl/dpa_gate.sv
module dpa_gate (
  input  logic master_i,
  input  logic en_i,
  input  logic we_i,
  input  logic lose_i,
  input  logic busy_ni,
  output logic busy_no,
  output logic wr_o
);
  logic inhibit;
  assign inhibit = master_i ? lose_i : !busy_ni;
  assign busy_no = master_i ? !lose_i : 1'b1;
  assign wr_o    = en_i && we_i && !inhibit;
endmodule

// File: rtl/dp_collision_arb.sv
module dp_collision_arb #(
  parameter int AW = 18
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          master_i,
  input  logic          l_en_i,
  input  logic          l_we_i,
  input  logic [AW-1:0] l_addr_i,
  input  logic          r_en_i,
  input  logic          r_we_i,
  input  logic [AW-1:0] r_addr_i,
  input  logic          l_busy_ni,
  input  logic          r_busy_ni,
  output logic          l_busy_no,
  output logic          r_busy_no,
  output logic          l_wr_o,
  output logic          r_wr_o
);
  logic l_fresh, r_fresh, l_lose, r_lose;

  dpa_arrival #(.AW(AW)) u_l_arr (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(l_en_i), .addr_i(l_addr_i), .fresh_o(l_fresh)
  );
  dpa_arrival #(.AW(AW)) u_r_arr (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(r_en_i), .addr_i(r_addr_i), .fresh_o(r_fresh)
  );

  dpa_lock #(.AW(AW)) u_lock (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .l_en_i(l_en_i), .r_en_i(r_en_i),
    .l_addr_i(l_addr_i), .r_addr_i(r_addr_i),
    .l_fresh_i(l_fresh), .r_fresh_i(r_fresh),
    .l_lose_o(l_lose), .r_lose_o(r_lose)
  );

  dpa_gate u_l_gate (
    .master_i(master_i), .en_i(l_en_i), .we_i(l_we_i), .lose_i(l_lose),
    .busy_ni(l_busy_ni), .busy_no(l_busy_no), .wr_o(l_wr_o)
  );
  dpa_gate u_r_gate (
    .master_i(master_i), .en_i(r_en_i), .we_i(r_we_i), .lose_i(r_lose),
    .busy_ni(r_busy_ni), .busy_no(r_busy_no), .wr_o(r_wr_o)
  );
endmodule

// File: rtl/dp_collision_arb_chk.sv
module dp_collision_arb_chk #(
  parameter int AW = 18
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          master_i,
  input logic          l_en_i,
  input logic          l_we_i,
  input logic [AW-1:0] l_addr_i,
  input logic          r_en_i,
  input logic          r_we_i,
  input logic [AW-1:0] r_addr_i,
  input logic          l_busy_ni,
  input logic          r_busy_ni,
  input logic          l_busy_no,
  input logic          r_busy_no,
  input logic          l_wr_o,
  input logic          r_wr_o
);
  logic match;
  assign match = l_en_i && r_en_i && (l_addr_i == r_addr_i);

  p_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && !match) |-> (l_busy_no && r_busy_no));

  p_one_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!l_busy_no && !r_busy_no));

  p_match_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && match) |-> $countones({l_busy_no, r_busy_no}) == 1);

  p_l_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && !l_busy_no) |-> !l_wr_o);

  p_r_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && !r_busy_no) |-> !r_wr_o);

  p_slave_out_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_i |-> (l_busy_no && r_busy_no));

  p_slave_inh_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!master_i && !l_busy_ni) |-> !l_wr_o);

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && match && $past(master_i && match && !r_busy_no)) |-> !r_busy_no);
endmodule

bind dp_collision_arb dp_collision_arb_chk #(.AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .master_i(master_i),
  .l_en_i(l_en_i), .l_we_i(l_we_i), .l_addr_i(l_addr_i),
  .r_en_i(r_en_i), .r_we_i(r_we_i), .r_addr_i(r_addr_i),
  .l_busy_ni(l_busy_ni), .r_busy_ni(r_busy_ni),
  .l_busy_no(l_busy_no), .r_busy_no(r_busy_no),
  .l_wr_o(l_wr_o), .r_wr_o(r_wr_o)
);

// File: tb/dp_collision_arb_test.sv
module dp_collision_arb_test;
  localparam int AW = 18;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 10000;

  logic clk = 1'b0, rst_n = 1'b0, master = 1'b1;
  logic l_en = 0, l_we = 0, r_en = 0, r_we = 0, l_bi = 1, r_bi = 1;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic l_bo, r_bo, l_wr, r_wr;

  int checks = 0, errors = 0, cycles = 0;
  // reference state: previous enables/addresses and locked winner (0 none, 1 left, 2 right)
  int m_prev_en[2];
  int m_prev_addr[2];
  int m_win = 0;
  int w_now = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dp_collision_arb #(.AW(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .master_i(master),
    .l_en_i(l_en), .l_we_i(l_we), .l_addr_i(l_addr),
    .r_en_i(r_en), .r_we_i(r_we), .r_addr_i(r_addr),
    .l_busy_ni(l_bi), .r_busy_ni(r_bi),
    .l_busy_no(l_bo), .r_busy_no(r_bo), .l_wr_o(l_wr), .r_wr_o(r_wr)
  );

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  // Drive one cycle, compare against the reference, then advance the reference.
  task automatic cyc(input logic le, input logic lw, input int la,
                     input logic re, input logic rw, input int ra);
    bit match, lf, rf, held;
    logic e_lb, e_rb, e_lw, e_rw;
    string tag;
    @(negedge clk);
    l_en = le; l_we = lw; l_addr = AW'(la);
    r_en = re; r_we = rw; r_addr = AW'(ra);
    #1;
    match = le && re && (la == ra);
    lf = le && (m_prev_en[0] == 0 || la != m_prev_addr[0]);
    rf = re && (m_prev_en[1] == 0 || ra != m_prev_addr[1]);
    held = 0;
    if (!match) w_now = 0;
    else if (m_win != 0) begin w_now = m_win; held = 1; end
    else if (rf && !lf) w_now = 1;
    else if (lf && !rf) w_now = 2;
    else w_now = 1;
    if (master) begin
      e_lb = (w_now != 2);
      e_rb = (w_now != 1);
      e_lw = le && lw && e_lb;
      e_rw = re && rw && e_rb;
      if (!match) tag = "R1";
      else if (held) tag = "R8";
      else if (lf && rf) tag = "R3";
      else tag = "R2";
      chk(tag, "l_busy", l_bo, e_lb);
      chk(tag, "r_busy", r_bo, e_rb);
      chk("R5", "l_wr", l_wr, e_lw);
      chk("R5", "r_wr", r_wr, e_rw);
    end else begin
      chk("R6", "l_busy", l_bo, 1'b1);
      chk("R6", "r_busy", r_bo, 1'b1);
      chk("R6", "l_wr", l_wr, le && lw && l_bi);
      chk("R6", "r_wr", r_wr, re && rw && r_bi);
    end
    chk("R4", "busy pair", (!l_bo && !r_bo), 1'b0);
    @(posedge clk);
    m_win = w_now;
    m_prev_en[0] = le; m_prev_addr[0] = la;
    m_prev_en[1] = re; m_prev_addr[1] = ra;
  endtask

  initial begin
    m_prev_en[0] = 0; m_prev_en[1] = 0;
    m_prev_addr[0] = 0; m_prev_addr[1] = 0;
    #(CLK_PERIOD * 2 + 2);
    chk("R1", "reset l_busy", l_bo, 1'b1);
    chk("R1", "reset r_busy", r_bo, 1'b1);
    rst_n = 1'b1;

    // R1: different addresses, both enabled
    cyc(1, 1, 'h100, 1, 1, 'h200);
    cyc(1, 1, 'h100, 1, 1, 'h201);
    cyc(0, 0, 'h300, 0, 0, 'h300);

    // R7 enable trigger, R2: left settled, right enables onto it
    cyc(1, 0, 'h3fffe, 0, 0, 'h3fffe);
    cyc(1, 1, 'h3fffe, 1, 1, 'h3fffe);
    chk("R7", "enable-rise collision r_busy", r_bo, 1'b0);
    cyc(1, 1, 'h3fffe, 1, 1, 'h3fffe);     // R8 hold
    cyc(1, 0, 'h3ffff, 1, 1, 'h3fffe);     // R8 release same cycle
    chk("R8", "release r_busy", r_bo, 1'b1);

    // R7 address trigger: right moves onto left's address
    cyc(1, 0, 'h055, 1, 1, 'h0aa);
    cyc(1, 1, 'h055, 1, 1, 'h055);
    chk("R7", "address-move collision r_busy", r_bo, 1'b0);
    cyc(0, 0, 'h055, 1, 1, 'h055);         // enable drops, R8 release

    // R2: right settled first, left moves onto it
    cyc(1, 1, 'h011, 1, 0, 'h022);
    cyc(1, 1, 'h022, 1, 1, 'h022);
    chk("R2", "late left l_busy", l_bo, 1'b0);
    // R8: both jump together (tie would favour left) but right keeps winning
    cyc(1, 1, 'h033, 1, 1, 'h033);
    chk("R8", "lock kept l_busy", l_bo, 1'b0);
    cyc(1, 1, 'h033, 1, 1, 'h033);
    cyc(0, 0, 'h0, 0, 0, 'h0);

    // R3: simultaneous arrival
    cyc(1, 1, 'h777, 1, 1, 'h777);
    chk("R3", "tie r_busy", r_bo, 1'b0);
    cyc(1, 1, 'h777, 1, 1, 'h777);
    cyc(0, 0, 'h0, 0, 0, 'h0);

    // R6: slave mode
    master = 1'b0;
    cyc(1, 1, 'h123, 1, 1, 'h123);
    l_bi = 1'b0;
    cyc(1, 1, 'h123, 1, 1, 'h123);
    chk("R6", "slave inhibit l_wr", l_wr, 1'b0);
    l_bi = 1'b1; r_bi = 1'b0;
    cyc(1, 1, 'h123, 1, 1, 'h124);
    r_bi = 1'b1;
    cyc(1, 1, 'h123, 1, 0, 'h124);
    cyc(0, 0, 'h0, 0, 0, 'h0);

    // back to master, fresh collision after slave interval
    master = 1'b1;
    cyc(0, 0, 'h0, 1, 0, 'h2);
    cyc(1, 1, 'h2, 1, 1, 'h2);
    cyc(0, 0, 'h0, 0, 0, 'h0);

    summary();
  end
endmodule